// File: doc/BRIEF.md
# Program-Step Capture Unit

This block samples values out of a sequenced DSP datapath at chosen program steps. It has four capture channels. Each channel holds a 9-bit step number and a 2-bit source code. In every clock cycle where the core's program counter equals a channel's step, the channel latches the chosen datapath bus into its 24-bit capture register. The four buses it can choose from are the multiplier output, the dB-conversion output, the multiplier data input and the multiplier coefficient input.

Channels 0 and 1 serve software. Their capture registers can be read through a combinational host read port. Channels 2 and 3 feed a serial data pin, which uses the same frame sync (LRCLK) and bit clock (BCLK) as the main serial audio input. This lets an external converter or processor receive two extra channels. Both serial clocks are sampled in the system clock domain, so they must be much slower than `clk`.

All four channels are configured through a single host write port. Each channel has its own setup address.

Top module: `pstep_capture`

## Requirements
- R1: While reset is asserted and just after it is released, every capture register and every setup register holds zero. `rd_data` is zero and `sdout` is low.
- R2: A write with `wr_en` high goes to the channel selected by `wr_addr`. Address 261 selects channel 0, 262 channel 1, 263 channel 2 and 264 channel 3. The new setup is taken at that clock edge: `wr_data[8:0]` is the step and `wr_data[10:9]` is the source code. A write to any other address changes no channel's setup.
- R3: A capture register changes only at a clock edge where the program counter equals that channel's step. At every other edge it keeps its value.
- R4: At a matching edge, the channel stores the bus chosen by its source code: 00 selects `src_mult`, 01 `src_db`, 10 `src_mdi` and 11 `src_mci`. The stored value can be read in the next cycle.
- R5: `rd_data` shows channel 0's capture register when `rd_addr` is 261 and channel 1's when it is 262, with no added latency. For every other address `rd_data` is zero.
- R6: Because the setup resets to zero, each channel captures `src_mult` whenever the program counter is 0 until it is configured.
- R7: The serial output changes only after a BCLK falling edge. The LRCLK-low phase carries channel 2 and the LRCLK-high phase carries channel 3. Each word goes out MSB first, with the MSB starting one BCLK period after the LRCLK transition. Every bit position after the 24th reads zero.
- R8: The word sent in a phase is the channel's capture value at that phase's LRCLK transition. A capture later in the phase changes only the word sent in the next phase of the same polarity.
- R9: Every step from 0 to 511 works, including both ends of the range.
- R10: A match on one channel never changes another channel's capture register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pc | input | 9 | Program counter of the DSP core |
| src_mult | input | 24 | Multiplier output bus |
| src_db | input | 24 | dB-conversion output bus |
| src_mdi | input | 24 | Multiplier data input bus |
| src_mci | input | 24 | Multiplier coefficient input bus |
| wr_en | input | 1 | Host setup write strobe |
| wr_addr | input | 9 | Host setup write address |
| wr_data | input | 11 | Setup word: source code in the top two bits, step in the low nine |
| rd_addr | input | 9 | Host readback address |
| rd_data | output | 24 | Readback value for the host-side channels |
| lrclk | input | 1 | Frame sync of the serial audio format |
| bclk | input | 1 | Bit clock of the serial audio format |
| sdout | output | 1 | Serial output carrying channels 2 and 3 |

## Verification
The following are checked in every cycle:
- capture registers hold their value without a step match;
- a matching channel stores the bus named by its source code;
- the readback mux returns the right channel, and zero elsewhere;
- setup is unaffected by idle cycles and by writes to foreign addresses;
- the serial pin changes only on a detected BCLK fall.

Other behaviour needs whole scenarios and is shown only by the bench:
- the serial word layout inside a frame: channel per phase, MSB one bit late, zero padding;
- freezing the word at the frame edge against a capture in mid-phase;
- the reset defaults;
- the exhaustive program-counter sweeps against each step and source code.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int unsigned NUM_CH      = 4;
  localparam int unsigned NUM_HOST_CH = 2;

  typedef enum logic [1:0] {
    SRC_MULT = 2'b00,
    SRC_DB   = 2'b01,
    SRC_MDI  = 2'b10,
    SRC_MCI  = 2'b11
  } cap_src_e;
endpackage

// File: rtl/pcap_setup_regs.sv
module pcap_setup_regs
  import pcap_pkg::*;
#(
  parameter int unsigned STEP_W   = 9,
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned CFG_BASE = 261,
  parameter int unsigned CFG_W    = STEP_W + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CFG_W-1:0]               wr_data,
  output logic [NUM_CH-1:0][STEP_W-1:0]  cfg_step,
  output logic [NUM_CH-1:0][1:0]         cfg_sel
);
  logic [NUM_CH-1:0]             addr_hit;
  logic [NUM_CH-1:0][STEP_W-1:0] step_d;
  logic [NUM_CH-1:0][1:0]        sel_d;

  // one address decoder per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign addr_hit[g] = (wr_addr == ADDR_W'(CFG_BASE + g));
  end

  always_comb begin
    step_d = cfg_step;
    sel_d  = cfg_sel;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_hit[i]) begin
        step_d[i] = wr_data[STEP_W-1:0];
        sel_d[i]  = wr_data[STEP_W+1:STEP_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_step <= '0;
      cfg_sel  <= '0;
    end else if (wr_en) begin
      cfg_step <= step_d;
      cfg_sel  <= sel_d;
    end
  end
endmodule

// File: rtl/pcap_channel.sv
module pcap_channel
  import pcap_pkg::*;
#(
  parameter int unsigned STEP_W = 9,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] pc,
  input  logic [STEP_W-1:0] step,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] src_mult,
  input  logic [DATA_W-1:0] src_db,
  input  logic [DATA_W-1:0] src_mdi,
  input  logic [DATA_W-1:0] src_mci,
  output logic [DATA_W-1:0] cap_q
);
  logic              step_hit;
  logic [DATA_W-1:0] pick;

  always_comb begin
    step_hit = (pc == step);
    case (cap_src_e'(sel))
      SRC_MULT: pick = src_mult;
      SRC_DB:   pick = src_db;
      SRC_MDI:  pick = src_mdi;
      SRC_MCI:  pick = src_mci;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (step_hit) begin
      cap_q <= pick;
    end
  end
endmodule

// File: rtl/pcap_serializer.sv
module pcap_serializer #(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic [DATA_W-1:0] word_left,
  input  logic [DATA_W-1:0] word_right,
  output logic              sdout,
  output logic              bit_tick
);
  logic [SYNC_STAGES-1:0] bclk_sync;
  logic [SYNC_STAGES-1:0] lrclk_sync;
  logic                   bclk_prev;
  logic                   lr_last;
  logic                   bclk_now;
  logic                   lr_now;
  logic                   frame_edge;
  logic [DATA_W-1:0]      shift_q;
  logic [DATA_W-1:0]      shift_d;
  logic                   out_d;

  // bring both serial clocks into the system domain through equal stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sync  <= '0;
      lrclk_sync <= '0;
      bclk_prev  <= 1'b0;
    end else begin
      bclk_sync  <= {bclk_sync[SYNC_STAGES-2:0], bclk};
      lrclk_sync <= {lrclk_sync[SYNC_STAGES-2:0], lrclk};
      bclk_prev  <= bclk_now;
    end
  end

  assign bclk_now = bclk_sync[SYNC_STAGES-1];
  assign lr_now   = lrclk_sync[SYNC_STAGES-1];

  always_comb begin
    bit_tick   = bclk_prev & ~bclk_now;
    frame_edge = lr_now ^ lr_last;
    if (frame_edge) begin
      shift_d = lr_now ? word_right : word_left;
    end else begin
      shift_d = {shift_q[DATA_W-2:0], 1'b0};
    end
    // pin lags the register by one bit period: MSB leaves one BCLK after the edge
    out_d = shift_q[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sdout   <= 1'b0;
      lr_last <= 1'b0;
    end else if (bit_tick) begin
      shift_q <= shift_d;
      sdout   <= out_d;
      lr_last <= lr_now;
    end
  end
endmodule

// File: rtl/pstep_capture.sv
module pstep_capture
  import pcap_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned STEP_W      = 9,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned CFG_BASE    = 261,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_W       = STEP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] pc,
  input  logic [DATA_W-1:0] src_mult,
  input  logic [DATA_W-1:0] src_db,
  input  logic [DATA_W-1:0] src_mdi,
  input  logic [DATA_W-1:0] src_mci,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lrclk,
  input  logic              bclk,
  output logic              sdout
);
  logic [1:0]                    rst_pipe;
  logic                          rst_int_n;
  logic [NUM_CH-1:0][STEP_W-1:0] cfg_step;
  logic [NUM_CH-1:0][1:0]        cfg_sel;
  logic [NUM_CH-1:0][DATA_W-1:0] cap;
  logic                          ser_tick;

  // assert at once, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  pcap_setup_regs #(
    .STEP_W  (STEP_W),
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE),
    .CFG_W   (CFG_W)
  ) u_setup (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_step(cfg_step),
    .cfg_sel (cfg_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pcap_channel #(
      .STEP_W(STEP_W),
      .DATA_W(DATA_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .pc      (pc),
      .step    (cfg_step[g]),
      .sel     (cfg_sel[g]),
      .src_mult(src_mult),
      .src_db  (src_db),
      .src_mdi (src_mdi),
      .src_mci (src_mci),
      .cap_q   (cap[g])
    );
  end

  pcap_serializer #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .word_left (cap[NUM_HOST_CH]),
    .word_right(cap[NUM_HOST_CH+1]),
    .sdout     (sdout),
    .bit_tick  (ser_tick)
  );

  // host readback: channels 0..NUM_HOST_CH-1 at consecutive addresses
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_HOST_CH; i++) begin
      if (rd_addr == ADDR_W'(CFG_BASE + i)) begin
        rd_data = cap[i];
      end
    end
  end
endmodule

// File: rtl/pcap_chk.sv
module pcap_chk
  import pcap_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned STEP_W   = 9,
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned CFG_BASE = 261
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [STEP_W-1:0]             pc,
  input logic [NUM_CH-1:0][STEP_W-1:0] cfg_step,
  input logic [NUM_CH-1:0][1:0]        cfg_sel,
  input logic [NUM_CH-1:0][DATA_W-1:0] cap,
  input logic [DATA_W-1:0]             src_mult,
  input logic [DATA_W-1:0]             src_db,
  input logic [DATA_W-1:0]             src_mdi,
  input logic [DATA_W-1:0]             src_mci,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [ADDR_W-1:0]             rd_addr,
  input logic [DATA_W-1:0]             rd_data,
  input logic                          ser_tick,
  input logic                          sdout
);
  logic [NUM_CH-1:0][DATA_W-1:0] want;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      case (cfg_sel[i])
        2'b00:   want[i] = src_mult;
        2'b01:   want[i] = src_db;
        2'b10:   want[i] = src_mdi;
        default: want[i] = src_mci;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    // R3
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc != cfg_step[g]) |=> $stable(cap[g]));
    // R4
    cap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc == cfg_step[g]) |=> (cap[g] == $past(want[g])));
  end

  // R5
  rd_chan0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(CFG_BASE)) |-> (rd_data == cap[0]));
  // R5
  rd_chan1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(CFG_BASE + 1)) |-> (rd_data == cap[1]));
  // R5
  rd_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr != ADDR_W'(CFG_BASE)) && (rd_addr != ADDR_W'(CFG_BASE + 1)))
      |-> (rd_data == '0));
  // R2
  cfg_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_addr < ADDR_W'(CFG_BASE)) || (wr_addr > ADDR_W'(CFG_BASE + NUM_CH - 1)))
      |=> ($stable(cfg_step) && $stable(cfg_sel)));
  // R7
  ser_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_tick |=> $stable(sdout));
endmodule

bind pstep_capture pcap_chk #(
  .DATA_W  (DATA_W),
  .STEP_W  (STEP_W),
  .ADDR_W  (ADDR_W),
  .CFG_BASE(CFG_BASE)
) u_pcap_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .pc      (pc),
  .cfg_step(cfg_step),
  .cfg_sel (cfg_sel),
  .cap     (cap),
  .src_mult(src_mult),
  .src_db  (src_db),
  .src_mdi (src_mdi),
  .src_mci (src_mci),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .ser_tick(ser_tick),
  .sdout   (sdout)
);

// File: tb/pstep_capture_bench.sv
module pstep_capture_bench;
  localparam int DW   = 24;
  localparam int SW   = 9;
  localparam int AW   = 9;
  localparam int BASE = 261;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SW-1:0] pc;
  logic [DW-1:0] src_mult, src_db, src_mdi, src_mci;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [SW+1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          lrclk, bclk;
  logic          sdout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pstep_capture u_pstep_capture (
    .clk(clk), .rst_n(rst_n), .pc(pc),
    .src_mult(src_mult), .src_db(src_db), .src_mdi(src_mdi), .src_mci(src_mci),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lrclk(lrclk), .bclk(bclk), .sdout(sdout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] srcv(input int k, input int pass, input int p);
    return {4'(k + 1), 3'(pass), 8'h00, 9'(p)};
  endfunction

  task automatic drive_src(input int pass, input int p);
    src_mult = srcv(0, pass, p);
    src_db   = srcv(1, pass, p);
    src_mdi  = srcv(2, pass, p);
    src_mci  = srcv(3, pass, p);
  endtask

  task automatic wcfg(input int addr, input int sel, input int step);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = {2'(sel), 9'(step)};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // one LRCLK phase of 32 bit periods, 16 system clocks each
  task automatic ser_half(input logic lv, input bit chk_en, input logic [DW-1:0] expw,
                          input string tag, input int mid_k, input logic [DW-1:0] mid_val);
    logic [31:0] got;
    got = '0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (k == 0) lrclk = lv;
      if (k == mid_k) src_mult = mid_val;
      repeat (8) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
      got[31-k] = sdout;
      repeat (3) @(negedge clk);
    end
    if (chk_en) check(tag, got, {1'b0, expw, 7'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sstep;
    logic [DW-1:0] model;
    rst_n = 1'b0; pc = 9'd1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = AW'(BASE); lrclk = 1'b0; bclk = 1'b1;
    drive_src(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 rd ch0", rd_data, 0);
    rd_addr = AW'(BASE + 1); #1;
    check("R1 rd ch1", rd_data, 0);
    check("R1 sdout", sdout, 0);

    // R6 default setup: step 0, multiplier output
    pc = 9'd0; src_mult = 24'h00C0DE; src_db = 24'h0BAD01; src_mdi = 24'h0BAD02; src_mci = 24'h0BAD03;
    repeat (2) @(negedge clk);
    rd_addr = AW'(BASE); #1;
    check("R6 ch0 default", rd_data, 24'h00C0DE);
    rd_addr = AW'(BASE + 1); #1;
    check("R6 ch1 default", rd_data, 24'h00C0DE);

    // R3/R4/R9 exhaustive program-counter sweeps per channel and source code
    for (int ch = 0; ch < 2; ch++) begin
      for (int sel = 0; sel < 4; sel++) begin
        sstep = (ch == 0) ? sel * 170 : 511 - sel * 170;
        wcfg(BASE + ch, sel, sstep);
        rd_addr = AW'(BASE + ch);
        for (int p = 0; p < 512; p++) begin
          @(negedge clk);
          pc = SW'(p);
          drive_src(0, p);
        end
        @(negedge clk);
        model = srcv(sel, 0, sstep);
        for (int p = 0; p < 512; p++) begin
          @(negedge clk);
          pc = SW'(p);
          drive_src(1, p);
          @(negedge clk);
          if (p == sstep) begin
            model = srcv(sel, 1, p);
            if (p == 0 || p == 511) check("R9 end step", rd_data, model);
            else check("R4 source", rd_data, model);
          end else begin
            check("R3 hold", rd_data, model);
          end
        end
      end
    end

    // R10 channel independence: ch0 step 510 mci, ch1 step 1 mci
    @(negedge clk);
    pc = 9'd510; src_mci = 24'hABCDEF;
    @(negedge clk);
    rd_addr = AW'(BASE); #1;
    check("R10 ch0 captures", rd_data, 24'hABCDEF);
    rd_addr = AW'(BASE + 1); #1;
    check("R10 ch1 untouched", rd_data, srcv(3, 1, 1));

    // R2 writes to foreign addresses are ignored
    wcfg(BASE - 1, 0, 100);
    wcfg(BASE + 4, 0, 100);
    @(negedge clk);
    pc = 9'd100; src_mult = 24'h111111; src_db = 24'h222222;
    repeat (2) @(negedge clk);
    rd_addr = AW'(BASE); #1;
    check("R2 addr 260 ignored", rd_data, 24'hABCDEF);
    rd_addr = AW'(BASE + 1); #1;
    check("R2 addr 265 ignored", rd_data, srcv(3, 1, 1));
    wcfg(BASE, 1, 100);
    @(negedge clk);
    rd_addr = AW'(BASE); #1;
    check("R2 addr 261 applied", rd_data, 24'h222222);

    // R5 readback decoding
    rd_addr = AW'(BASE + 2); #1;
    check("R5 addr 263", rd_data, 0);
    rd_addr = AW'(BASE + 3); #1;
    check("R5 addr 264", rd_data, 0);
    rd_addr = AW'(0); #1;
    check("R5 addr 0", rd_data, 0);
    rd_addr = AW'(511); #1;
    check("R5 addr 511", rd_data, 0);

    // R7/R8 serial channels: ch2 mult, ch3 db, both at step 5
    wcfg(BASE + 2, 0, 5);
    wcfg(BASE + 3, 1, 5);
    @(negedge clk);
    pc = 9'd5; src_mult = 24'hC3A5F0; src_db = 24'h800001;
    repeat (4) @(negedge clk);
    ser_half(1'b1, 1'b1, 24'h800001, "R7 right phase", -1, '0);
    ser_half(1'b0, 1'b1, 24'hC3A5F0, "R8 left frozen", 10, 24'h123456);
    ser_half(1'b1, 1'b1, 24'h800001, "R7 right again", -1, '0);
    ser_half(1'b0, 1'b1, 24'h123456, "R8 left updated", -1, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule